// File: doc/BRIEF.md
# External Frame Exposure Sequencer

This block runs one global-shutter capture cycle each time an external master pulses its exposure request line. The request is first brought into the local clock domain. A rising edge on the synchronized request starts a precharge of the whole pixel array, which lasts a fixed, parameterized number of clock cycles. While the request stays high after that, the array integrates light. When the request drops, the block reads the frame out one row at a time. It does this by pulsing a row-advance strobe at a fixed spacing, alongside the index of the row being read.

The external master sets the exposure time directly through the width of its pulse. The block does not time the exposure itself. It enforces only two rules. The pulse must outlast the precharge, or the frame is thrown away and a sticky error flag is raised. Readout waits until the pulse ends, and a new request is not accepted until the last row has gone out.

Two inputs return the block to idle. Reset clears everything. Power-down freezes and clears the sequencing state and the counters, but keeps the error flag.

Top module: `frame_exposure_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `busy`, `precharge`, `integrating`, `reading`, `row_adv` and `short_err` are 0 and `row_idx` is 0.
- R2: `exp_req` passes through a two-flop synchronizer. If `exp_req` is first sampled high at rising edge k while the block is idle, `precharge` and `busy` go high after edge k+2.
- R3: If `exp_req` is held high for W clock cycles with W > PRE_CYCLES, then `precharge` stays high for exactly PRE_CYCLES cycles. `integrating` then stays high for exactly W − PRE_CYCLES cycles.
- R4: Readout begins in the cycle after integration ends, with `reading` high. `row_adv` pulses exactly ROWS times, one cycle each, ROW_GAP cycles apart, with the first pulse in the first `reading` cycle. `row_idx` equals 0, 1, …, ROWS−1 on successive pulses. `reading` lasts ROWS·ROW_GAP cycles and then the block returns to idle.
- R5: If W ≤ PRE_CYCLES, `precharge` lasts W cycles and the block returns to idle with `short_err` set. No `integrating` cycle and no `row_adv` pulse occur for that frame.
- R6: `short_err` is sticky. Later good frames and power-down leave it set, and only `rst` clears it.
- R7: A request that rises while `reading` is high is ignored. If the request is still high when readout ends, no new frame starts, and its later fall also starts nothing.
- R8: `busy` is high exactly when one of `precharge`, `integrating` or `reading` is high.
- R9: While `pwdn` is high, from the cycle after it is sampled high, the block is idle with all counters cleared and `row_adv` low. `short_err` keeps its value. After release, a new frame runs with the full precharge length and the full row count.
- R10: At most one of `precharge`, `integrating` and `reading` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset, clears all state |
| pwdn | input | 1 | Power-down: holds the sequencer idle, counters cleared |
| exp_req | input | 1 | Asynchronous exposure request from the external master |
| precharge | output | 1 | Pixel array precharge in progress |
| integrating | output | 1 | Array integrating while the request is held |
| reading | output | 1 | Row-by-row readout in progress |
| row_adv | output | 1 | One-cycle strobe per row read out |
| row_idx | output | $clog2(ROWS) | Index of the row being read, valid with `row_adv` |
| busy | output | 1 | A capture cycle is in progress |
| short_err | output | 1 | Sticky flag: a request ended before precharge finished |

## Verification
The assertions assume that `exp_req` changes only away from clock edges and that `pwdn` is never high together with an edge on the request. Under that assumption the phase outputs form a clean precharge, integrate, read sequence, broken only by an error or by power-down. The stimulus changes every input on the falling clock edge and holds each request level for a whole number of cycles, so the request width W is exact. It drops the request only while power-down is active, and it keeps the request low on the release of power-down, so the cleared synchronizer never sees a false rising edge.

// File: rtl/fexp_pkg.sv
package fexp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_INT  = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    typedef struct packed {
        logic pre;
        logic integ;
        logic rd;
    } phase_flags_t;

    function automatic phase_flags_t phase_flags(phase_e p);
        phase_flags_t f;
        f.pre   = (p == PH_PRE);
        f.integ = (p == PH_INT);
        f.rd    = (p == PH_READ);
        return f;
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fexp_sync.sv
module fexp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              q_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst || clr) sh <= '0;
                else            sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || clr) sh <= '0;
                else            sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) q_prev <= 1'b0;
        else            q_prev <= sh[STAGES-1];
    end

    assign q    = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~q_prev;
endmodule

// File: rtl/fexp_ctrl.sv
module fexp_ctrl
    import fexp_pkg::*;
#(
    parameter int PRE_CYCLES = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   halt,
    input  logic   req_lvl,
    input  logic   req_rise,
    input  logic   rows_done,
    output phase_e phase,
    output logic   err_set
);
    localparam int PW = cnt_width(PRE_CYCLES);
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_CYCLES - 1);

    phase_e         state, state_nx;
    logic [PW-1:0]  pre_cnt, pre_cnt_nx;

    always_comb begin
        state_nx   = state;
        pre_cnt_nx = pre_cnt;
        err_set    = 1'b0;
        unique case (state)
            PH_IDLE: begin
                pre_cnt_nx = '0;
                if (req_rise) state_nx = PH_PRE;
            end
            PH_PRE: begin
                if (!req_lvl) begin
                    err_set    = 1'b1;
                    state_nx   = PH_IDLE;
                    pre_cnt_nx = '0;
                end else if (pre_cnt == PRE_LAST) begin
                    state_nx   = PH_INT;
                    pre_cnt_nx = '0;
                end else begin
                    pre_cnt_nx = pre_cnt + 1'b1;
                end
            end
            PH_INT: begin
                if (!req_lvl) state_nx = PH_READ;
            end
            PH_READ: begin
                if (rows_done) state_nx = PH_IDLE;
            end
            default: state_nx = PH_IDLE;
        endcase
        if (halt) err_set = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            state   <= PH_IDLE;
            pre_cnt <= '0;
        end else begin
            state   <= state_nx;
            pre_cnt <= pre_cnt_nx;
        end
    end

    assign phase = state;
endmodule

// File: rtl/fexp_rowgen.sv
module fexp_rowgen
    import fexp_pkg::*;
#(
    parameter int ROWS    = 288,
    parameter int ROW_GAP = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      halt,
    input  logic                      en,
    output logic                      row_adv,
    output logic [cnt_width(ROWS)-1:0] row_idx,
    output logic                      last
);
    localparam int RW = cnt_width(ROWS);
    localparam int GW = cnt_width(ROW_GAP);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(ROW_GAP - 1);

    logic [RW-1:0] row_q;
    logic [GW-1:0] gap_q;
    logic          gap_end;

    assign gap_end = (gap_q == GAP_LAST);

    always_ff @(posedge clk) begin
        if (rst || halt || !en) begin
            row_q <= '0;
            gap_q <= '0;
        end else if (gap_end) begin
            gap_q <= '0;
            if (row_q != ROW_LAST) row_q <= row_q + 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign row_adv = en && (gap_q == '0);
    assign row_idx = row_q;
    assign last    = en && gap_end && (row_q == ROW_LAST);
endmodule

// File: rtl/frame_exposure_seq.sv
module frame_exposure_seq
    import fexp_pkg::*;
#(
    parameter int PRE_CYCLES  = 64,
    parameter int ROWS        = 288,
    parameter int ROW_GAP     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pwdn,
    input  logic                       exp_req,
    output logic                       precharge,
    output logic                       integrating,
    output logic                       reading,
    output logic                       row_adv,
    output logic [cnt_width(ROWS)-1:0] row_idx,
    output logic                       busy,
    output logic                       short_err
);
    localparam int RW = cnt_width(ROWS);

    logic         req_s, req_rise;
    logic         rows_done, err_set;
    phase_e       phase;
    phase_flags_t flags;
    logic         err_q;
    logic [RW-1:0] idx_w;
    logic         adv_w;

    fexp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .clr (pwdn),
        .d   (exp_req),
        .q   (req_s),
        .rise(req_rise)
    );

    fexp_ctrl #(.PRE_CYCLES(PRE_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .halt     (pwdn),
        .req_lvl  (req_s),
        .req_rise (req_rise),
        .rows_done(rows_done),
        .phase    (phase),
        .err_set  (err_set)
    );

    assign flags = phase_flags(phase);

    fexp_rowgen #(.ROWS(ROWS), .ROW_GAP(ROW_GAP)) u_rows (
        .clk    (clk),
        .rst    (rst),
        .halt   (pwdn),
        .en     (flags.rd),
        .row_adv(adv_w),
        .row_idx(idx_w),
        .last   (rows_done)
    );

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    assign precharge   = flags.pre;
    assign integrating = flags.integ;
    assign reading     = flags.rd;
    assign row_adv     = adv_w;
    assign row_idx     = idx_w;
    assign busy        = (phase != PH_IDLE);
    assign short_err   = err_q;
endmodule

// File: rtl/fexp_checker.sv
module fexp_checker #(
    parameter int RW = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          pwdn,
    input logic          precharge,
    input logic          integrating,
    input logic          reading,
    input logic          row_adv,
    input logic [RW-1:0] row_idx,
    input logic          busy,
    input logic          short_err
);
    // R8
    busy_phase_chk: assert property (@(posedge clk) disable iff (rst)
        busy == (precharge || integrating || reading));

    // R10
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({precharge, integrating, reading}));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        short_err |=> short_err);

    // R9
    pwdn_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pwdn |=> (!busy && !row_adv));

    // R2
    start_pre_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> precharge);

    // R3
    pre_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(precharge) |-> (integrating || !busy));

    // R4
    read_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reading) |-> ($past(integrating) && row_adv && (row_idx == '0)));

    // R5
    err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(short_err) |-> ($past(precharge) && !busy));

    // R4
    adv_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        row_adv |-> reading);
endmodule

bind frame_exposure_seq fexp_checker #(.RW(RW)) u_fexp_chk (
    .clk        (clk),
    .rst        (rst),
    .pwdn       (pwdn),
    .precharge  (precharge),
    .integrating(integrating),
    .reading    (reading),
    .row_adv    (row_adv),
    .row_idx    (row_idx),
    .busy       (busy),
    .short_err  (short_err)
);

// File: tb/frame_exposure_seq_test.sv
`timescale 1ns/1ps
module frame_exposure_seq_test;
    localparam int PRE  = 6;
    localparam int ROWS = 5;
    localparam int GAP  = 3;
    localparam int RW   = $clog2(ROWS);

    typedef struct {
        int pre;
        int integ;
        int rows;
        bit err;
    } frame_exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwdn = 1'b0;
    logic exp_req = 1'b0;
    logic precharge, integrating, reading, row_adv, busy, short_err;
    logic [RW-1:0] row_idx;

    int compared = 0;
    int mismatched = 0;
    bit err_model = 1'b0;
    bit finished = 1'b0;
    frame_exp_t sb_q[$];

    always #2 clk = ~clk;

    frame_exposure_seq #(
        .PRE_CYCLES(PRE), .ROWS(ROWS), .ROW_GAP(GAP), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst(rst), .pwdn(pwdn), .exp_req(exp_req),
        .precharge(precharge), .integrating(integrating), .reading(reading),
        .row_adv(row_adv), .row_idx(row_idx), .busy(busy), .short_err(short_err)
    );

    task automatic check(input string req, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // driver: one request pulse of w cycles, expected result pushed to scoreboard
    task automatic frame(input int w);
        frame_exp_t e;
        if (w <= PRE) begin
            err_model = 1'b1;
            e = '{pre: w, integ: 0, rows: 0, err: 1'b1};
        end else begin
            e = '{pre: PRE, integ: w - PRE, rows: ROWS, err: err_model};
        end
        sb_q.push_back(e);
        @(negedge clk) exp_req = 1'b1;
        repeat (w) @(negedge clk);
        exp_req = 1'b0;
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 short_err in reset", short_err, 0);
        rst = 1'b0;
        err_model = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset",
              {precharge, integrating, reading, row_adv, busy, short_err}, 0);
        check("R1 row_idx after reset", row_idx, 0);
    endtask

    // monitor
    int pc, ic, rc, cyc, last_adv;
    bit prev_busy, aborted, phase_bad;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            pc = 0; ic = 0; rc = 0; prev_busy = 1'b0; aborted = 1'b0; phase_bad = 1'b0;
        end else begin
            if (busy != (precharge | integrating | reading)) phase_bad = 1'b1;
            if (pwdn && prev_busy) aborted = 1'b1;
            if (busy) begin
                if (precharge) pc++;
                if (integrating) ic++;
                if (row_adv) begin
                    check("R4 row_idx order", int'(row_idx), rc);
                    if (rc > 0) check("R4 row spacing", cyc - last_adv, GAP);
                    last_adv = cyc;
                    rc++;
                end
            end
            if (prev_busy && !busy) begin
                if (aborted) begin
                    aborted = 1'b0;
                end else if (sb_q.size() == 0) begin
                    check("R7 unexpected frame", 1, 0);
                end else begin
                    frame_exp_t e;
                    e = sb_q.pop_front();
                    check(e.err ? "R5 precharge cycles" : "R3 precharge cycles", pc, e.pre);
                    check(e.err ? "R5 integrate cycles" : "R3 integrate cycles", ic, e.integ);
                    check(e.err ? "R5 row pulses" : "R4 row pulses", rc, e.rows);
                    check(e.err ? "R5 short_err" : "R6 short_err", short_err, e.err);
                    check("R8 busy matches phases", phase_bad, 0);
                end
                pc = 0; ic = 0; rc = 0; phase_bad = 1'b0;
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2: start latency
        @(negedge clk) exp_req = 1'b1;
        sb_q.push_back('{pre: PRE, integ: 10 - PRE, rows: ROWS, err: 1'b0});
        @(negedge clk);  check("R2 not busy after 1 edge", busy, 0);
        @(negedge clk);  check("R2 not busy after 2 edges", busy, 0);
        @(negedge clk);  check("R2 precharge after 3 edges", precharge, 1);
        repeat (7) @(negedge clk);
        exp_req = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        frame(20);
        frame(PRE + 1);
        frame(PRE);       // R5 boundary
        frame(2);         // R5
        frame(15);        // R6 error stays set

        // R7: request during readout ignored
        sb_q.push_back('{pre: PRE, integ: 12 - PRE, rows: ROWS, err: err_model});
        @(negedge clk) exp_req = 1'b1;
        repeat (12) @(negedge clk);
        exp_req = 1'b0;
        while (!reading) @(negedge clk);
        repeat (2) @(negedge clk);
        exp_req = 1'b1;
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R7 no restart while held", busy, 0);
        exp_req = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 no restart on fall", busy, 0);
        check("R7 scoreboard drained", sb_q.size(), 0);

        // R9: power-down mid integration
        @(negedge clk) exp_req = 1'b1;
        repeat (PRE + 5) @(negedge clk);
        check("R9 integrating before pwdn", integrating, 1);
        pwdn = 1'b1;
        @(negedge clk);
        check("R9 idle in pwdn", {precharge, integrating, reading, row_adv, busy}, 0);
        check("R9 short_err kept", short_err, 1);
        exp_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 still idle", busy, 0);
        pwdn = 1'b0;
        repeat (3) @(negedge clk);
        frame(14);        // R9 full frame after release

        // R6: reset clears error
        do_reset();
        check("R6 cleared by reset", short_err, 0);
        frame(9);
        check("R3 scoreboard drained", sb_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule